// File: doc/BRIEF.md
# Machine-Mode Interrupt Control Unit

This block collects interrupt sources for a small machine-mode processor core and turns them into one request line with a cause code. It takes up to 32 external interrupt lines, a timer-pending input from an outside timer, and the core's global interrupt enable. Each external line is fixed at build time as disabled, edge-latched or level-sensitive. Per-line enable bits and per-line pending bits sit in two custom CSRs. The three standard sources (external summary, software, timer) are gated by the interrupt-enable CSR.

The core reaches the unit through a simple CSR port. A write takes effect at the clock edge that samples it. A read returns the register chosen by `csr_addr` one cycle later. When software clears a set pending bit, the unit sends a one-cycle end-of-interrupt strobe on that line, so the source knows its service is done. The core uses `irq_req` and `irq_cause` to enter its trap handler. Saving state on trap entry is left to the core.

Top module: `mirq_unit`

## Requirements
- R1: After a synchronous reset, the mask, pending, interrupt-enable and software-pending state is 0. `irq_req`, `irq_cause` and `eoi` are 0, and every CSR reads 0 apart from mip bit 7, which shows the timer input.
- R2: A line whose bit is 1 in `OFF_LINES` never becomes pending. Its bit in the mask CSR reads 0 even after writing a 1, and its `eoi` never pulses.
- R3: On a line whose bit is 1 in `LATCH_LINES`, an input high for one cycle sets its pending bit (CSR 0x7C1, bit i = line i) at the next edge. The bit stays set until software writes 0 to it. Writing 1 leaves it unchanged. If the input is high in the same cycle as the clearing write, the set wins.
- R4: On a line with `LATCH_LINES` bit 0, the pending bit equals the input level sampled at the previous edge. Writes to the pending CSR do not change it.
- R5: The mask CSR at 0x7C0 (bit i = line i, 1 = enabled) is read/write.
- R6: A write to 0x7C1 that has bit i at 0 while pending bit i is 1 drives `eoi[i]` high for exactly the one cycle after the write edge. This does not depend on the mask, on mie or on `glb_ie`. `eoi` is never high except after a write to 0x7C1.
- R7: mip bit 11 reads 1 exactly when some pending bit is also set in the mask. It cannot be written, and it returns to 0 by itself once the pending bits are cleared or masked.
- R8: mie (0x304) holds only bits 11, 7 and 3, and all other bits read 0. In mip (0x344), software writes bit 3 (software pending). Bit 7 shows `timer_pend` and ignores writes.
- R9: `irq_req` is 1 in the cycle after an edge at which `glb_ie` was 1 and at least one source had both its mip bit and its mie bit set. Otherwise it is 0.
- R10: While `irq_req` is 1, `irq_cause` has bit 31 set and code 11 for external, 3 for software or 7 for timer. The priority is external, then software, then timer. While `irq_req` is 0, `irq_cause` is 0.
- R11: `csr_rdata` is registered and shows the addressed CSR one edge after the address is presented. Addresses other than 0x304, 0x344, 0x7C0 and 0x7C1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | NLINES | External interrupt lines |
| timer_pend | input | 1 | Timer compare reached |
| glb_ie | input | 1 | Global interrupt enable from the core status register |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Registered CSR read data |
| irq_req | output | 1 | Interrupt request to the core |
| irq_cause | output | 32 | Cause code of the winning source |
| eoi | output | NLINES | One-cycle end-of-interrupt strobes |

## Verification
The bench builds the unit with `OFF_LINES = 32'h8000_0010` and `LATCH_LINES = 32'h0000_FFFF`. Line 4 is then a disabled line inside the latched range, line 31 is a disabled line inside the level range, lines 0 to 15 (except 4) are latched and lines 16 to 30 are level-sensitive. With this build, one run covers clearing a latched line, trying to clear a level line, and driving a disabled line in each mode. It also covers the edge-set versus clear collision and the three-way priority race, using the software and timer sources together with an external line.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

  localparam int CSR_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADDR_IE   = 12'h304;
  localparam logic [ADDR_W-1:0] ADDR_IP   = 12'h344;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 12'h7C0;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 12'h7C1;

  localparam int BIT_SW  = 3;
  localparam int BIT_TM  = 7;
  localparam int BIT_EXT = 11;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_TM   = 2'd3
  } src_e;

  function automatic logic [CSR_W-1:0] cause_of(input src_e s);
    logic [CSR_W-1:0] c;
    c = '0;
    case (s)
      SRC_EXT: c = {1'b1, {(CSR_W-5){1'b0}}, 4'd11};
      SRC_SW:  c = {1'b1, {(CSR_W-5){1'b0}}, 4'd3};
      SRC_TM:  c = {1'b1, {(CSR_W-5){1'b0}}, 4'd7};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mirq_line_bank.sv
module mirq_line_bank #(
  parameter int                 NLINES      = 32,
  parameter logic [NLINES-1:0]  OFF_LINES   = '0,
  parameter logic [NLINES-1:0]  LATCH_LINES = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] ext_irq,
  input  logic              pend_wr,
  input  logic [NLINES-1:0] pend_wdata,
  output logic [NLINES-1:0] pend,
  output logic [NLINES-1:0] eoi
);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (OFF_LINES[i]) begin : g_off
      assign pend[i] = 1'b0;
      assign eoi[i]  = 1'b0;
    end else begin : g_on
      logic pend_q;
      logic eoi_q;
      logic clr;

      assign clr = pend_wr & ~pend_wdata[i];

      if (LATCH_LINES[i]) begin : g_latch
        always_ff @(posedge clk) begin
          if (rst) pend_q <= 1'b0;
          else     pend_q <= ext_irq[i] | (pend_q & ~clr);
        end
      end else begin : g_level
        always_ff @(posedge clk) begin
          if (rst) pend_q <= 1'b0;
          else     pend_q <= ext_irq[i];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) eoi_q <= 1'b0;
        else     eoi_q <= clr & pend_q;
      end

      assign pend[i] = pend_q;
      assign eoi[i]  = eoi_q;
    end
  end

endmodule

// File: rtl/mirq_csr_file.sv
module mirq_csr_file
  import mirq_pkg::*;
#(
  parameter int                NLINES    = 32,
  parameter logic [NLINES-1:0] OFF_LINES = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [CSR_W-1:0]  csr_wdata,
  input  logic [NLINES-1:0] pend,
  input  logic              ext_sum,
  input  logic              timer_pend,
  output logic [NLINES-1:0] mask,
  output logic              ie_ext,
  output logic              ie_tm,
  output logic              ie_sw,
  output logic              sw_pend,
  output logic              pend_wr,
  output logic [CSR_W-1:0]  csr_rdata
);

  logic [NLINES-1:0] mask_q;
  logic              ie_ext_q, ie_tm_q, ie_sw_q, sw_q;
  logic [CSR_W-1:0]  rd_q;
  logic [CSR_W-1:0]  rd_d;

  assign pend_wr = csr_we && (csr_addr == ADDR_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      ie_ext_q <= 1'b0;
      ie_tm_q  <= 1'b0;
      ie_sw_q  <= 1'b0;
      sw_q     <= 1'b0;
    end else if (csr_we) begin
      case (csr_addr)
        ADDR_MASK: mask_q <= csr_wdata[NLINES-1:0] & ~OFF_LINES;
        ADDR_IE: begin
          ie_ext_q <= csr_wdata[BIT_EXT];
          ie_tm_q  <= csr_wdata[BIT_TM];
          ie_sw_q  <= csr_wdata[BIT_SW];
        end
        ADDR_IP:   sw_q <= csr_wdata[BIT_SW];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    case (csr_addr)
      ADDR_MASK: rd_d[NLINES-1:0] = mask_q;
      ADDR_PEND: rd_d[NLINES-1:0] = pend;
      ADDR_IE: begin
        rd_d[BIT_EXT] = ie_ext_q;
        rd_d[BIT_TM]  = ie_tm_q;
        rd_d[BIT_SW]  = ie_sw_q;
      end
      ADDR_IP: begin
        rd_d[BIT_EXT] = ext_sum;
        rd_d[BIT_TM]  = timer_pend;
        rd_d[BIT_SW]  = sw_q;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign mask      = mask_q;
  assign ie_ext    = ie_ext_q;
  assign ie_tm     = ie_tm_q;
  assign ie_sw     = ie_sw_q;
  assign sw_pend   = sw_q;
  assign csr_rdata = rd_q;

endmodule

// File: rtl/mirq_arbiter.sv
module mirq_arbiter
  import mirq_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pend,
  input  logic [NLINES-1:0] mask,
  input  logic              ie_ext,
  input  logic              ie_tm,
  input  logic              ie_sw,
  input  logic              sw_pend,
  input  logic              timer_pend,
  input  logic              glb_ie,
  output logic              ext_sum,
  output logic              irq_req,
  output logic [CSR_W-1:0]  irq_cause
);

  logic             ext_rdy, sw_rdy, tm_rdy;
  src_e             win;
  logic             req_q;
  logic [CSR_W-1:0] cause_q;

  assign ext_sum = |(pend & mask);
  assign ext_rdy = ext_sum & ie_ext;
  assign sw_rdy  = sw_pend & ie_sw;
  assign tm_rdy  = timer_pend & ie_tm;

  always_comb begin
    if (!glb_ie)      win = SRC_NONE;
    else if (ext_rdy) win = SRC_EXT;
    else if (sw_rdy)  win = SRC_SW;
    else if (tm_rdy)  win = SRC_TM;
    else              win = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      req_q   <= (win != SRC_NONE);
      cause_q <= cause_of(win);
    end
  end

  assign irq_req   = req_q;
  assign irq_cause = cause_q;

endmodule

// File: rtl/mirq_unit.sv
module mirq_unit
  import mirq_pkg::*;
#(
  parameter int                NLINES      = 32,
  parameter logic [NLINES-1:0] OFF_LINES   = '0,
  parameter logic [NLINES-1:0] LATCH_LINES = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] ext_irq,
  input  logic              timer_pend,
  input  logic              glb_ie,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq_req,
  output logic [31:0]       irq_cause,
  output logic [NLINES-1:0] eoi
);

  logic [NLINES-1:0] pend_vec;
  logic [NLINES-1:0] mask_vec;
  logic              ie_ext, ie_tm, ie_sw, sw_pend, pend_wr, ext_sum;

  mirq_line_bank #(
    .NLINES(NLINES), .OFF_LINES(OFF_LINES), .LATCH_LINES(LATCH_LINES)
  ) u_lines (
    .clk(clk), .rst(rst), .ext_irq(ext_irq),
    .pend_wr(pend_wr), .pend_wdata(csr_wdata[NLINES-1:0]),
    .pend(pend_vec), .eoi(eoi)
  );

  mirq_csr_file #(
    .NLINES(NLINES), .OFF_LINES(OFF_LINES)
  ) u_csr (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .pend(pend_vec), .ext_sum(ext_sum),
    .timer_pend(timer_pend), .mask(mask_vec), .ie_ext(ie_ext),
    .ie_tm(ie_tm), .ie_sw(ie_sw), .sw_pend(sw_pend),
    .pend_wr(pend_wr), .csr_rdata(csr_rdata)
  );

  mirq_arbiter #(
    .NLINES(NLINES)
  ) u_arb (
    .clk(clk), .rst(rst), .pend(pend_vec), .mask(mask_vec),
    .ie_ext(ie_ext), .ie_tm(ie_tm), .ie_sw(ie_sw), .sw_pend(sw_pend),
    .timer_pend(timer_pend), .glb_ie(glb_ie), .ext_sum(ext_sum),
    .irq_req(irq_req), .irq_cause(irq_cause)
  );

endmodule

// File: rtl/mirq_unit_chk.sv
module mirq_unit_chk #(
  parameter int                NLINES    = 32,
  parameter logic [NLINES-1:0] OFF_LINES = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_ie,
  input logic              csr_we,
  input logic [11:0]       csr_addr,
  input logic              irq_req,
  input logic [31:0]       irq_cause,
  input logic [NLINES-1:0] eoi,
  input logic [NLINES-1:0] pend_vec,
  input logic [NLINES-1:0] mask_vec
);

  // R1: first cycle out of reset shows no request and no strobe
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_req && eoi == '0));

  // R2: disabled lines hold no pending or enable state
  assert_off_lines_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ((pend_vec & OFF_LINES) == '0) && ((mask_vec & OFF_LINES) == '0));

  // R6: strobes follow only a pending-CSR write
  assert_eoi_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    (eoi != '0) |-> $past(csr_we && csr_addr == 12'h7C1));

  // R7: an external cause needs a masked-in pending bit one cycle earlier
  assert_ext_cause_source_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_cause[3:0] == 4'd11) |-> $past((pend_vec & mask_vec) != '0));

  // R9: request only after the global enable was set
  assert_req_needs_glb_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(glb_ie));

  // R10: cause is well formed with a request, zero without
  assert_cause_form_R10: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_cause[31] &&
                 (irq_cause[3:0] == 4'd3 || irq_cause[3:0] == 4'd7 || irq_cause[3:0] == 4'd11)));
  assert_cause_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_cause == 32'd0));

endmodule

bind mirq_unit mirq_unit_chk #(
  .NLINES(NLINES), .OFF_LINES(OFF_LINES)
) u_chk (
  .clk(clk), .rst(rst), .glb_ie(glb_ie), .csr_we(csr_we),
  .csr_addr(csr_addr), .irq_req(irq_req), .irq_cause(irq_cause),
  .eoi(eoi), .pend_vec(pend_vec), .mask_vec(mask_vec)
);

// File: tb/mirq_unit_test.sv
module mirq_unit_test;

  localparam int          NL  = 32;
  localparam logic [31:0] OFF = 32'h8000_0010;
  localparam logic [31:0] LAT = 32'h0000_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] ext_irq = '0;
  logic          timer_pend = 1'b0;
  logic          glb_ie = 1'b0;
  logic          csr_we = 1'b0;
  logic [11:0]   csr_addr = '0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   csr_rdata;
  logic          irq_req;
  logic [31:0]   irq_cause;
  logic [NL-1:0] eoi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mirq_unit #(.NLINES(NL), .OFF_LINES(OFF), .LATCH_LINES(LAT)) uut (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .timer_pend(timer_pend),
    .glb_ie(glb_ie), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_req(irq_req),
    .irq_cause(irq_cause), .eoi(eoi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  task automatic pulse_line(input int i);
    @(negedge clk);
    ext_irq[i] = 1'b1;
    @(negedge clk);
    ext_irq[i] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq_req", {31'd0, irq_req}, 32'd0);
    check("R1 irq_cause", irq_cause, 32'd0);
    check("R1 eoi", eoi, 32'd0);
    csr_read(12'h7C0, v); check("R1 mask", v, 32'd0);
    csr_read(12'h7C1, v); check("R1 pend", v, 32'd0);
    csr_read(12'h304, v); check("R1 mie", v, 32'd0);
    csr_read(12'h344, v); check("R1 mip", v, 32'd0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    pulse_line(4);
    @(negedge clk); ext_irq[31] = 1'b1;
    repeat (2) @(negedge clk);
    csr_read(12'h7C1, v); check("R2 off lines never pending", v, 32'd0);
    csr_write(12'h7C0, 32'hFFFF_FFFF);
    csr_read(12'h7C0, v); check("R2/R5 mask readback", v, ~OFF);
    csr_write(12'h7C1, 32'h0);
    check("R2 no eoi on off lines", eoi, 32'd0);
    ext_irq[31] = 1'b0;
    csr_write(12'h7C0, 32'h0);
    csr_read(12'h7C0, v); check("R5 mask cleared", v, 32'd0);
  endtask

  task automatic t_latched();
    logic [31:0] v;
    pulse_line(2);
    repeat (3) @(negedge clk);
    csr_read(12'h7C1, v); check("R3 latched held", v, 32'h4);
    csr_write(12'h7C1, 32'hFFFF_FFFF);
    check("R6 no eoi when bit written 1", eoi, 32'd0);
    csr_read(12'h7C1, v); check("R3 write 1 keeps", v, 32'h4);
    csr_write(12'h7C1, ~32'h4);
    check("R6 eoi pulse", eoi, 32'h4);
    @(negedge clk);
    check("R6 eoi one cycle", eoi, 32'd0);
    csr_read(12'h7C1, v); check("R3 cleared by write", v, 32'd0);
    // set and clear in the same cycle: set wins
    @(negedge clk);
    ext_irq[3] = 1'b1; csr_we = 1'b1; csr_addr = 12'h7C1; csr_wdata = 32'h0;
    @(negedge clk);
    ext_irq[3] = 1'b0; csr_we = 1'b0;
    csr_read(12'h7C1, v); check("R3 set beats clear", v, 32'h8);
    csr_write(12'h7C1, 32'h0);
    check("R6 eoi line 3", eoi, 32'h8);
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); ext_irq[20] = 1'b1;
    @(negedge clk);
    csr_read(12'h7C1, v); check("R4 level pending", v, 32'h0010_0000);
    csr_write(12'h7C1, 32'h0);
    check("R6 eoi on level line", eoi, 32'h0010_0000);
    csr_read(12'h7C1, v); check("R4 write has no effect", v, 32'h0010_0000);
    @(negedge clk); ext_irq[20] = 1'b0;
    @(negedge clk);
    csr_read(12'h7C1, v); check("R4 follows input low", v, 32'd0);
  endtask

  task automatic t_summary();
    logic [31:0] v;
    csr_write(12'h7C0, 32'h200);
    pulse_line(9);
    csr_read(12'h344, v); check("R7 summary set", v, 32'h800);
    csr_write(12'h7C0, 32'h0);
    csr_read(12'h344, v); check("R7 cleared by masking", v, 32'h0);
    csr_write(12'h7C0, 32'h200);
    csr_read(12'h344, v); check("R7 set again", v, 32'h800);
    csr_write(12'h7C1, 32'h0);
    csr_read(12'h344, v); check("R7 cleared by pend clear", v, 32'h0);
    csr_write(12'h344, 32'h880);
    csr_read(12'h344, v); check("R7/R8 bits 11,7 ignore writes", v, 32'h0);
  endtask

  task automatic t_enables();
    logic [31:0] v;
    csr_write(12'h304, 32'hFFFF_FFFF);
    csr_read(12'h304, v); check("R8 mie bits", v, 32'h888);
    csr_write(12'h344, 32'h8);
    csr_read(12'h344, v); check("R8 software pending", v, 32'h8);
    @(negedge clk); timer_pend = 1'b1;
    csr_read(12'h344, v); check("R8 timer shown", v, 32'h88);
    csr_read(12'h123, v); check("R11 unknown address", v, 32'h0);
  endtask

  task automatic t_request();
    repeat (2) @(negedge clk);
    check("R9 no request without glb_ie", {31'd0, irq_req}, 32'd0);
    @(negedge clk); glb_ie = 1'b1;
    @(negedge clk);
    check("R9 request", {31'd0, irq_req}, 32'd1);
    check("R10 software over timer", irq_cause, 32'h8000_0003);
    pulse_line(9);
    @(negedge clk);
    check("R10 external first", irq_cause, 32'h8000_000B);
    csr_write(12'h7C1, 32'h0);
    csr_write(12'h344, 32'h0);
    @(negedge clk);
    check("R10 timer last", irq_cause, 32'h8000_0007);
    csr_write(12'h304, 32'h0);
    @(negedge clk);
    check("R9 mie gates request", {31'd0, irq_req}, 32'd0);
    check("R10 cause idle", irq_cause, 32'd0);
    timer_pend = 1'b0; glb_ie = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_latched();
    t_level();
    t_summary();
    t_enables();
    t_request();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule